// File: doc/BRIEF.md
# Register Lock Hazard and Forward Unit

This unit sits between the operand-fetch step of an 8-bit microcontroller pipeline and its internal data RAM. It watches for read-after-write conflicts between an instruction and the one issued just before it. Each instruction that reads its operands successfully also records its own destination byte addresses as locks. A later read that names a locked byte is never served from stale storage. Depending on the case, the unit either tells the execute step which of the older instruction's two results to take in place of a memory read, or refuses the read so that the requester retries.

Every request carries up to two sources and up to two destinations. A source can be the accumulator, a direct byte address, a banked working register, or a byte reached through a banked pointer register. The working-register address is built from the bank-select bits of the status word. The unit holds the accumulator and the status word locally, applies write-back to them, and passes every other write-back address on to the RAM. A lock-release strobe from write-back frees the oldest occupied pair of locks.

Each request is answered exactly one clock later with a valid flag, an error flag, a forwarding selector and the two read bytes. The RAM is read combinationally through four read ports: one pointer port and one data port for each source.

Top module: `hzl_lock_fwd`

## Requirements
- R1: After reset all four lock slots hold the empty marker 0xFF, the accumulator and status word are 0x00, and every response output is 0.
- R2: A source whose effective address equals the first current lock is forwarded from destination 1. If it instead equals the second current lock, it is forwarded from destination 2. The first slot wins when both match.
- R3: The forward selector is 0 (none), 1 (dest1 to src1), 2 (dest2 to src1), 3 (dest1 to src2), 4 (dest2 to src2) or 5 (dest1 to src1 and dest2 to src2). Any other combination of forwards is answered not-valid with selector 0.
- R4: An unforwarded source reads from its effective address. Address 0xE0 returns the accumulator, 0xD0 returns the status word, and any other address returns the RAM byte. The bytes come back on the data outputs with valid 1, and a forwarded or absent source reads as 0.
- R5: A working-register source (kind 3, register number in arg bits 2:0) has address {3'b000, status[4:3], n}. A pointer source (kind 4, pointer select in arg bit 0) reads its pointer from register 0 or 1 of the same bank.
- R6: If 0xD0 is in either current lock slot, a kind 3 or kind 4 source answers with error 1 and valid 0.
- R7: If the pointer register of a kind 4 source is in either current lock slot, the answer is valid 0 with error 0. Otherwise the pointed-to byte is compared with the locks and read like a direct address.
- R8: A valid request moves the current pair into the previous pair. Its first destination, or 0xFF if dst_cnt is 0, goes into current slot 1. Its second destination, or 0xFF if dst_cnt is below 2, goes into current slot 2. A refused request leaves all locks unchanged.
- R9: A lock release clears the current pair when the previous pair is entirely 0xFF, and clears the previous pair otherwise. When a release and a valid request arrive in the same cycle, the release is applied before the shift.
- R10: Locks in the previous pair never cause forwarding or a stall.
- R11: A source address of 0xFF never matches a lock slot.
- R12: Write-back to 0xE0 or 0xD0 updates the local accumulator or status word at the clock edge. Any other write-back address drives the RAM write port in the same cycle.
- R13: rsp_done is 1 exactly in the cycle after a cycle with req_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operand read request |
| src1_kind | input | 3 | Source 1 kind: 0 none, 1 accumulator, 2 direct, 3 register, 4 pointer |
| src1_arg | input | 8 | Source 1 address or register number |
| src2_kind | input | 3 | Source 2 kind |
| src2_arg | input | 8 | Source 2 address or register number |
| dst_cnt | input | 2 | Number of destinations of the requesting instruction |
| dst1 | input | 8 | First destination address |
| dst2 | input | 8 | Second destination address |
| lock_release | input | 1 | Free the oldest occupied lock pair |
| wb_en | input | 1 | Write-back strobe |
| wb_addr | input | 8 | Write-back address |
| wb_data | input | 8 | Write-back data |
| ram_paddr | output | 2x8 | Pointer read address per source |
| ram_pdata | input | 2x8 | Pointer read data per source |
| ram_daddr | output | 2x8 | Operand read address per source |
| ram_ddata | input | 2x8 | Operand read data per source |
| ram_we | output | 1 | RAM write enable |
| ram_waddr | output | 8 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| rsp_done | output | 1 | Response present |
| rsp_ok | output | 1 | Read valid; requester retries when 0 |
| rsp_err | output | 1 | Bank bits locked |
| rsp_fwd | output | 3 | Forward selector |
| rsp_data1 | output | 8 | Source 1 byte |
| rsp_data2 | output | 8 | Source 2 byte |

## Verification
The response outputs are registered once, so every answer to a request driven before a rising edge appears just after that edge. The bench drives on the falling edge and checks on the next falling edge. Lock state, the accumulator and the status word change at that same edge, so the bench model applies write-back, release and the lock shift only after it has checked the answer. It computes the following request against the updated state. The RAM write port is combinational and is checked within the cycle of the write-back. A cycle without a request is checked one edge later for a quiet rsp_done.

// File: rtl/hzl_pkg.sv
package hzl_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 8;
    localparam int NSRC     = 2;
    localparam int REGN_W   = 3;
    localparam int BANK_LO  = 3;
    localparam int BANK_HI  = 4;
    localparam int BANK_W   = BANK_HI - BANK_LO + 1;
    localparam int FWD_W    = 3;

    localparam logic [ADDR_W-1:0] LOCK_EMPTY = '1;
    localparam logic [ADDR_W-1:0] ACC_ADDR   = 8'hE0;
    localparam logic [ADDR_W-1:0] PSW_ADDR   = 8'hD0;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_ACC  = 3'd1,
        SRC_DIR  = 3'd2,
        SRC_REG  = 3'd3,
        SRC_IND  = 3'd4
    } src_kind_e;

    typedef enum logic [FWD_W-1:0] {
        FWD_NONE  = 3'd0,
        FWD_D1_S1 = 3'd1,
        FWD_D2_S1 = 3'd2,
        FWD_D1_S2 = 3'd3,
        FWD_D2_S2 = 3'd4,
        FWD_BOTH  = 3'd5
    } fwd_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] a;
        logic [ADDR_W-1:0] b;
    } lock_pair_t;

    typedef struct packed {
        logic              hit1;
        logic              hit2;
        logic              stall;
        logic              err;
        logic [DATA_W-1:0] data;
    } src_res_t;

    localparam lock_pair_t EMPTY_PAIR = '{a: LOCK_EMPTY, b: LOCK_EMPTY};

    function automatic logic slot_hit(input logic [ADDR_W-1:0] addr,
                                      input logic [ADDR_W-1:0] slot);
        return (slot != LOCK_EMPTY) && (addr == slot);
    endfunction

    function automatic logic pair_hit(input logic [ADDR_W-1:0] addr,
                                      input lock_pair_t pair);
        return slot_hit(addr, pair.a) || slot_hit(addr, pair.b);
    endfunction

    function automatic logic [ADDR_W-1:0] bank_reg_addr(input logic [BANK_W-1:0] bank,
                                                        input logic [REGN_W-1:0] num);
        return {{(ADDR_W-BANK_W-REGN_W){1'b0}}, bank, num};
    endfunction

endpackage

// File: rtl/hzl_lock_table.sv
module hzl_lock_table
    import hzl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       release_i,
    input  logic       take_i,
    input  lock_pair_t new_i,
    output lock_pair_t cur_o,
    output lock_pair_t prev_o
);

    lock_pair_t cur_q, prev_q;
    lock_pair_t cur_r, prev_r;
    lock_pair_t cur_n, prev_n;

    // release frees the oldest occupied pair, then a take shifts
    always_comb begin
        cur_r  = cur_q;
        prev_r = prev_q;
        if (release_i) begin
            if (prev_q == EMPTY_PAIR) begin
                cur_r = EMPTY_PAIR;
            end else begin
                prev_r = EMPTY_PAIR;
            end
        end
        cur_n  = cur_r;
        prev_n = prev_r;
        if (take_i) begin
            prev_n = cur_r;
            cur_n  = new_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= EMPTY_PAIR;
            prev_q <= EMPTY_PAIR;
        end else begin
            cur_q  <= cur_n;
            prev_q <= prev_n;
        end
    end

    assign cur_o  = cur_q;
    assign prev_o = prev_q;

endmodule

// File: rtl/hzl_src_resolve.sv
module hzl_src_resolve
    import hzl_pkg::*;
(
    input  logic [2:0]        kind_i,
    input  logic [ADDR_W-1:0] arg_i,
    input  lock_pair_t        cur_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] psw_i,
    output logic [ADDR_W-1:0] ptr_addr_o,
    input  logic [DATA_W-1:0] ptr_data_i,
    output logic [ADDR_W-1:0] data_addr_o,
    input  logic [DATA_W-1:0] data_i,
    output src_res_t          res_o
);

    logic              psw_locked;
    logic              ptr_locked;
    logic              uses_bank;
    logic              active;
    logic [BANK_W-1:0] bank;
    logic [ADDR_W-1:0] eff_addr;
    src_kind_e         kind;

    always_comb begin
        kind       = src_kind_e'(kind_i);
        bank       = psw_i[BANK_HI:BANK_LO];
        psw_locked = pair_hit(PSW_ADDR, cur_i);
        ptr_addr_o = bank_reg_addr(bank, {{(REGN_W-1){1'b0}}, arg_i[0]});
        ptr_locked = pair_hit(ptr_addr_o, cur_i);

        active   = 1'b1;
        eff_addr = LOCK_EMPTY;
        case (kind)
            SRC_ACC: eff_addr = ACC_ADDR;
            SRC_DIR: eff_addr = arg_i;
            SRC_REG: eff_addr = bank_reg_addr(bank, arg_i[REGN_W-1:0]);
            SRC_IND: eff_addr = ptr_data_i;
            default: active   = 1'b0;
        endcase
        data_addr_o = eff_addr;

        uses_bank   = (kind == SRC_REG) || (kind == SRC_IND);
        res_o.err   = uses_bank && psw_locked;
        res_o.stall = (kind == SRC_IND) && !psw_locked && ptr_locked;
        res_o.hit1  = active && slot_hit(eff_addr, cur_i.a);
        res_o.hit2  = active && !res_o.hit1 && slot_hit(eff_addr, cur_i.b);

        if (!active) begin
            res_o.data = '0;
        end else if (eff_addr == ACC_ADDR) begin
            res_o.data = acc_i;
        end else if (eff_addr == PSW_ADDR) begin
            res_o.data = psw_i;
        end else begin
            res_o.data = data_i;
        end
    end

endmodule

// File: rtl/hzl_fwd_encode.sv
module hzl_fwd_encode
    import hzl_pkg::*;
(
    input  src_res_t          res1_i,
    input  src_res_t          res2_i,
    output fwd_sel_e          fwd_o,
    output logic              ok_o,
    output logic              err_o,
    output logic [DATA_W-1:0] data1_o,
    output logic [DATA_W-1:0] data2_o
);

    logic     blocked;
    logic     unrep;
    fwd_sel_e code;

    always_comb begin
        blocked = res1_i.err | res2_i.err | res1_i.stall | res2_i.stall;
        unrep   = 1'b0;
        code    = FWD_NONE;
        case ({res1_i.hit1, res1_i.hit2, res2_i.hit1, res2_i.hit2})
            4'b0000: code  = FWD_NONE;
            4'b1000: code  = FWD_D1_S1;
            4'b0100: code  = FWD_D2_S1;
            4'b0010: code  = FWD_D1_S2;
            4'b0001: code  = FWD_D2_S2;
            4'b1001: code  = FWD_BOTH;
            default: unrep = 1'b1;
        endcase
        ok_o    = !blocked && !unrep;
        err_o   = res1_i.err | res2_i.err;
        fwd_o   = ok_o ? code : FWD_NONE;
        data1_o = (ok_o && !res1_i.hit1 && !res1_i.hit2) ? res1_i.data : '0;
        data2_o = (ok_o && !res2_i.hit1 && !res2_i.hit2) ? res2_i.data : '0;
    end

endmodule

// File: rtl/hzl_lock_fwd.sv
module hzl_lock_fwd
    import hzl_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic [2:0]                    src1_kind,
    input  logic [7:0]                    src1_arg,
    input  logic [2:0]                    src2_kind,
    input  logic [7:0]                    src2_arg,
    input  logic [1:0]                    dst_cnt,
    input  logic [7:0]                    dst1,
    input  logic [7:0]                    dst2,
    input  logic                          lock_release,
    input  logic                          wb_en,
    input  logic [7:0]                    wb_addr,
    input  logic [7:0]                    wb_data,
    output logic [1:0][7:0]               ram_paddr,
    input  logic [1:0][7:0]               ram_pdata,
    output logic [1:0][7:0]               ram_daddr,
    input  logic [1:0][7:0]               ram_ddata,
    output logic                          ram_we,
    output logic [7:0]                    ram_waddr,
    output logic [7:0]                    ram_wdata,
    output logic                          rsp_done,
    output logic                          rsp_ok,
    output logic                          rsp_err,
    output logic [2:0]                    rsp_fwd,
    output logic [7:0]                    rsp_data1,
    output logic [7:0]                    rsp_data2
);

    lock_pair_t        cur_locks, prev_locks, new_locks;
    logic [DATA_W-1:0] acc_q, psw_q;
    src_res_t          res [NSRC];
    logic [2:0]        kinds [NSRC];
    logic [ADDR_W-1:0] args  [NSRC];
    fwd_sel_e          fwd;
    logic              ok, err, take;
    logic [DATA_W-1:0] data1, data2;

    assign kinds[0] = src1_kind;
    assign kinds[1] = src2_kind;
    assign args[0]  = src1_arg;
    assign args[1]  = src2_arg;

    // local special-function registers
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            psw_q <= '0;
        end else if (wb_en) begin
            if (wb_addr == ACC_ADDR) acc_q <= wb_data;
            if (wb_addr == PSW_ADDR) psw_q <= wb_data;
        end
    end

    assign ram_we    = wb_en && (wb_addr != ACC_ADDR) && (wb_addr != PSW_ADDR);
    assign ram_waddr = wb_addr;
    assign ram_wdata = wb_data;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        hzl_src_resolve u_res (
            .kind_i      (kinds[s]),
            .arg_i       (args[s]),
            .cur_i       (cur_locks),
            .acc_i       (acc_q),
            .psw_i       (psw_q),
            .ptr_addr_o  (ram_paddr[s]),
            .ptr_data_i  (ram_pdata[s]),
            .data_addr_o (ram_daddr[s]),
            .data_i      (ram_ddata[s]),
            .res_o       (res[s])
        );
    end

    hzl_fwd_encode u_enc (
        .res1_i  (res[0]),
        .res2_i  (res[1]),
        .fwd_o   (fwd),
        .ok_o    (ok),
        .err_o   (err),
        .data1_o (data1),
        .data2_o (data2)
    );

    assign take        = req_valid && ok;
    assign new_locks.a = (dst_cnt != 2'd0) ? dst1 : LOCK_EMPTY;
    assign new_locks.b = (dst_cnt >= 2'd2) ? dst2 : LOCK_EMPTY;

    hzl_lock_table u_locks (
        .clk       (clk),
        .rst       (rst),
        .release_i (lock_release),
        .take_i    (take),
        .new_i     (new_locks),
        .cur_o     (cur_locks),
        .prev_o    (prev_locks)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_done  <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_fwd   <= '0;
            rsp_data1 <= '0;
            rsp_data2 <= '0;
        end else begin
            rsp_done  <= req_valid;
            rsp_ok    <= req_valid && ok;
            rsp_err   <= req_valid && err;
            rsp_fwd   <= req_valid ? fwd : FWD_NONE;
            rsp_data1 <= req_valid ? data1 : '0;
            rsp_data2 <= req_valid ? data2 : '0;
        end
    end

endmodule

// File: rtl/hzl_lock_fwd_chk.sv
module hzl_lock_fwd_chk
    import hzl_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [2:0] src1_kind,
    input logic [7:0] src1_arg,
    input logic       wb_en,
    input logic [7:0] wb_addr,
    input logic       ram_we,
    input logic       rsp_done,
    input logic       rsp_ok,
    input logic       rsp_err,
    input logic [2:0] rsp_fwd,
    input logic [7:0] rsp_data1,
    input logic [7:0] rsp_data2
);

    AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_done); // R13

    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_done); // R13

    AST_ERR_NOT_VALID: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> !rsp_ok); // R6

    AST_FWD_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
        rsp_fwd <= 3'd5); // R3

    AST_REFUSED_IS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rsp_ok |-> (rsp_fwd == 3'd0 && rsp_data1 == 8'h00 && rsp_data2 == 8'h00)); // R3

    AST_EMPTY_MARK_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && src1_kind == 3'd2 && src1_arg == 8'hFF)
        |=> !(rsp_fwd inside {3'd1, 3'd2, 3'd5})); // R11

    AST_RAM_WRITE_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (wb_en && wb_addr != 8'hE0 && wb_addr != 8'hD0)); // R12

endmodule

bind hzl_lock_fwd hzl_lock_fwd_chk chk_i (.*);

// File: tb/hzl_lock_fwd_tb.sv
module hzl_lock_fwd_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic       req_valid = 0, lock_release = 0, wb_en = 0;
    logic [2:0] src1_kind = 0, src2_kind = 0;
    logic [7:0] src1_arg = 0, src2_arg = 0, dst1 = 0, dst2 = 0, wb_addr = 0, wb_data = 0;
    logic [1:0] dst_cnt = 0;
    logic [1:0][7:0] ram_paddr, ram_pdata, ram_daddr, ram_ddata;
    logic       ram_we, rsp_done, rsp_ok, rsp_err;
    logic [7:0] ram_waddr, ram_wdata, rsp_data1, rsp_data2;
    logic [2:0] rsp_fwd;

    logic [7:0] mem [256];
    assign ram_pdata[0] = mem[ram_paddr[0]];
    assign ram_pdata[1] = mem[ram_paddr[1]];
    assign ram_ddata[0] = mem[ram_daddr[0]];
    assign ram_ddata[1] = mem[ram_daddr[1]];
    always @(posedge clk) if (ram_we) mem[ram_waddr] <= ram_wdata;

    hzl_lock_fwd dut_i (.*);

    int n_chk = 0, n_fail = 0;
    bit done_run = 0;

    // reference state
    logic [7:0] m_c1, m_c2, m_p1, m_p2, m_acc, m_psw;

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic mt(logic [7:0] a, logic [7:0] s);
        return (s != 8'hFF) && (a == s);
    endfunction

    task automatic model_src(input logic [2:0] k, input logic [7:0] arg,
                             output logic h1, output logic h2, output logic st,
                             output logic er, output logic [7:0] d);
        logic pl, act;
        logic [7:0] pa, e;
        pl  = mt(8'hD0, m_c1) || mt(8'hD0, m_c2);
        pa  = {3'b000, m_psw[4:3], 2'b00, arg[0]};
        act = 1;
        e   = 8'hFF;
        case (k)
            3'd1: e = 8'hE0;
            3'd2: e = arg;
            3'd3: e = {3'b000, m_psw[4:3], arg[2:0]};
            3'd4: e = mem[pa];
            default: act = 0;
        endcase
        er = (k == 3'd3 || k == 3'd4) && pl;
        st = (k == 3'd4) && !pl && (mt(pa, m_c1) || mt(pa, m_c2));
        h1 = act && mt(e, m_c1);
        h2 = act && !h1 && mt(e, m_c2);
        d  = !act ? 8'h00 : (e == 8'hE0) ? m_acc : (e == 8'hD0) ? m_psw : mem[e];
    endtask

    task automatic do_req(string tag, logic rv, logic [2:0] k1, logic [7:0] a1,
                          logic [2:0] k2, logic [7:0] a2, logic [1:0] cnt,
                          logic [7:0] d1, logic [7:0] d2, logic rel,
                          logic we, logic [7:0] wa, logic [7:0] wd);
        logic h11, h12, s1, e1, h21, h22, s2, e2, unrep, eok, eerr;
        logic [7:0] v1, v2;
        logic [2:0] efwd;
        string t;
        @(negedge clk);
        chk("R13", "done while idle", rsp_done, 0);
        req_valid = rv; src1_kind = k1; src1_arg = a1; src2_kind = k2; src2_arg = a2;
        dst_cnt = cnt; dst1 = d1; dst2 = d2; lock_release = rel;
        wb_en = we; wb_addr = wa; wb_data = wd;
        #1;
        if (we) chk("R12", "ram_we", ram_we, (wa != 8'hE0 && wa != 8'hD0));
        model_src(k1, a1, h11, h12, s1, e1, v1);
        model_src(k2, a2, h21, h22, s2, e2, v2);
        unrep = 0; efwd = 0;
        case ({h11, h12, h21, h22})
            4'b0000: efwd = 0;
            4'b1000: efwd = 1;
            4'b0100: efwd = 2;
            4'b0010: efwd = 3;
            4'b0001: efwd = 4;
            4'b1001: efwd = 5;
            default: unrep = 1;
        endcase
        eok  = !(e1 | e2 | s1 | s2 | unrep);
        eerr = e1 | e2;
        if (!eok) efwd = 0;
        if (!eok || h11 || h12) v1 = 0;
        if (!eok || h21 || h22) v2 = 0;
        t = tag;
        if (t == "") t = eerr ? "R6" : (s1 | s2) ? "R7" : unrep ? "R3" : (efwd != 0) ? "R2" : "R4";
        @(negedge clk);
        chk("R13", "done", rsp_done, rv);
        if (rv) begin
            chk(t, "ok", rsp_ok, eok);
            chk(t, "err", rsp_err, eerr);
            chk(t, "fwd", rsp_fwd, efwd);
            chk(t, "data1", rsp_data1, v1);
            chk(t, "data2", rsp_data2, v2);
        end
        if (we && wa == 8'hE0) m_acc = wd;
        if (we && wa == 8'hD0) m_psw = wd;
        if (rel) begin
            if (m_p1 == 8'hFF && m_p2 == 8'hFF) begin m_c1 = 8'hFF; m_c2 = 8'hFF; end
            else begin m_p1 = 8'hFF; m_p2 = 8'hFF; end
        end
        if (rv && eok) begin
            m_p1 = m_c1; m_p2 = m_c2;
            m_c1 = (cnt != 0) ? d1 : 8'hFF;
            m_c2 = (cnt >= 2) ? d2 : 8'hFF;
        end
        req_valid = 0; lock_release = 0; wb_en = 0;
    endtask

    task automatic finish_run();
        if (!done_run) begin
            done_run = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [15:0] lf;
        logic [7:0] pool [16];
        for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 8'hFF);
        mem[8'h01] = 8'h30;
        pool = '{8'h00, 8'h01, 8'h08, 8'h09, 8'h18, 8'h1D, 8'h30, 8'h31,
                 8'hE0, 8'hD0, 8'hFF, 8'h45, 8'h10, 8'h11, 8'h19, 8'h1A};
        m_c1 = 8'hFF; m_c2 = 8'hFF; m_p1 = 8'hFF; m_p2 = 8'hFF; m_acc = 0; m_psw = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        @(negedge clk);
        chk("R1", "done", rsp_done, 0);
        chk("R1", "ok", rsp_ok, 0);
        chk("R1", "fwd", rsp_fwd, 0);
        // R1: empty locks, zero accumulator
        do_req("R1", 1, 3'd1, 8'h00, 3'd2, 8'h30, 0, 0, 0, 0, 0, 0, 0);
        do_req("R4", 1, 3'd2, 8'h45, 3'd2, 8'hD0, 2, 8'h30, 8'h31, 0, 0, 0, 0);
        // both destinations feed both sources in order
        do_req("R3", 1, 3'd2, 8'h30, 3'd2, 8'h31, 1, 8'h40, 0, 0, 0, 0, 0);
        do_req("R10", 1, 3'd2, 8'h30, 3'd2, 8'h40, 0, 0, 0, 0, 0, 0, 0);
        do_req("R8", 1, 3'd2, 8'h40, 3'd0, 0, 2, 8'h30, 8'h31, 0, 0, 0, 0);
        do_req("R3", 1, 3'd2, 8'h31, 3'd2, 8'h30, 0, 0, 0, 0, 0, 0, 0);
        do_req("R2", 1, 3'd0, 0, 3'd2, 8'h31, 1, 8'hFF, 0, 0, 0, 0, 0);
        do_req("R11", 1, 3'd2, 8'hFF, 3'd2, 8'hFF, 1, 8'hD0, 0, 0, 0, 0, 0);
        do_req("R6", 1, 3'd3, 8'h03, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0);
        do_req("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        do_req("R6", 1, 3'd4, 8'h00, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0);
        do_req("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        do_req("R9", 1, 3'd3, 8'h03, 3'd1, 0, 1, 8'h01, 0, 0, 0, 0, 0);
        do_req("R7", 1, 3'd4, 8'h01, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0);
        do_req("R7", 1, 3'd4, 8'h00, 3'd0, 0, 0, 0, 0, 1, 0, 0, 0);
        do_req("R12", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'hD0, 8'h18);
        do_req("R5", 1, 3'd3, 8'h05, 3'd4, 8'h01, 0, 0, 0, 0, 1, 8'hE0, 8'h5A);
        do_req("R12", 1, 3'd1, 0, 3'd2, 8'h50, 0, 0, 0, 0, 1, 8'h50, 8'hC3);
        do_req("R12", 1, 3'd2, 8'h50, 3'd2, 8'hE0, 2, 8'h1D, 8'hE0, 0, 0, 0, 0);
        do_req("R5", 1, 3'd3, 8'h05, 3'd1, 0, 0, 0, 0, 0, 0, 0, 0);
        // sweep over a small address pool
        lf = 16'hACE1;
        for (int n = 0; n < 700; n++) begin
            logic [2:0] k1, k2;
            logic [7:0] a1, a2, d1, d2, wa, wd;
            logic [1:0] cnt;
            logic rel, we, rv;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            k1 = 3'(lf[2:0] % 5); a1 = pool[lf[7:4]];
            k2 = 3'(lf[10:8] % 5); a2 = pool[lf[15:12]];
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cnt = lf[1:0]; d1 = pool[lf[5:2]]; d2 = pool[lf[9:6]];
            rel = (lf[12:10] == 3'd0);
            rv  = (lf[15:13] != 3'd7);
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            we = (lf[2:0] == 3'd0);
            wa = pool[lf[6:3]];
            wd = lf[15:8];
            do_req("", rv, k1, a1, k2, a2, cnt, d1, d2, rel, we, wa, wd);
        end
        @(negedge clk);
        chk("R13", "done while idle", rsp_done, 0);
        finish_run();
    end

endmodule